// File: doc/BRIEF.md
# Galois Pseudo-Random Bit Generator with Seed Load

This block is an N-bit linear feedback shift register built in the internal-XOR (Galois) arrangement. The feedback polynomial is fixed at elaboration by a tap mask parameter. On every clock the register moves one place toward bit 0. The bit that leaves at bit 0 drives the feedback: when it is 1, the tap mask is XORed into the shifted value. Each tap has its own XOR gate at its register stage, so the path from any flop to the next state is one XOR deep, however many taps the polynomial has.

A load strobe picks, bit by bit, between the computed next state and a seed word. A seed of all zeros would lock the register into its fixed point, so it is replaced by the value 1. Reset also puts the register at 1. The serial output is bit 0 of the state, which is the bit the next step shifts out. The full state is also available as a word.

The default configuration is 4 bits with polynomial x^4 + x^3 + 1 (tap mask 0xC). An 8-bit build with polynomial x^8 + x^6 + x^5 + x^4 + 1 uses tap mask 0xB8.

Top module: `galois_lfsr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes 1 (only bit 0 set) after that edge.
- R2: With `load_i` low, each edge replaces state S by (S >> 1) XOR (S[0] ? TAP_MASK : 0). The shift fills bit N-1 with 0.
- R3: With `load_i` high and `seed_i` nonzero, the state after the edge equals `seed_i`, whatever the current state.
- R4: With `load_i` high and `seed_i` equal to zero, the state after the edge is 1.
- R5: With the default 4-bit mask 0xC, starting from any nonzero state, the sequence visits 15 distinct nonzero states and returns to its start after exactly 15 steps.
- R6: With WIDTH 8 and mask 0xB8, the sequence returns to its start after exactly 255 steps, with no repeat before that.
- R7: After reset, the state is never all zeros.
- R8: `serial_o` always equals bit 0 of `state_o`.
- R9: Reset takes priority over load. When `rst_n` is low and `load_i` is high at the same edge, the state still becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | When high, the next state is taken from the seed |
| seed_i | input | WIDTH | Seed word; zero is replaced by 1 |
| serial_o | output | 1 | Bit that the next step shifts out (state bit 0) |
| state_o | output | WIDTH | Current register contents |

## Verification
Two pairs of functions can meet in one cycle: a seed load can arrive on the same edge as a normal step, and a reset can arrive on the same edge as a seed load. The bench pulses `load_i` at random points while the register runs, with random seeds that include zero. It also holds `load_i` high during a reset. Each cycle, a bench model that gives load priority over stepping and reset priority over load predicts the state, and the bench compares the whole state word with that prediction.

// File: rtl/galois_lfsr_pkg.sv
// Package: shared helpers for the Galois shift register.
// Assumes: widths are at least 2 bits.
package galois_lfsr_pkg;

    // Default feedback mask for x^4 + x^3 + 1 in right-shifting Galois form
    localparam logic [3:0] DEFAULT_MASK4 = 4'hC;

    // Mask for x^8 + x^6 + x^5 + x^4 + 1 in right-shifting Galois form
    localparam logic [7:0] MASK8 = 8'hB8;

endpackage

// File: rtl/lfsr_step.sv
// Module: lfsr_step
// Computes the next Galois state from the current one. Every tap has its
// own XOR at its own stage, so the depth is a single XOR for any mask.
// Assumes: TAP_MASK has its top bit set (polynomial degree equals WIDTH).
module lfsr_step #(
    parameter int               WIDTH    = 4,
    parameter logic [WIDTH-1:0] TAP_MASK = 4'hC
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic fb;

    // Feedback is the bit leaving at the low end
    assign fb = cur_i[0];

    // One stage per bit: shifted neighbour, XORed with the feedback where a tap sits
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == WIDTH - 1) begin : g_top
            assign nxt_o[i] = TAP_MASK[i] & fb;
        end else if (TAP_MASK[i]) begin : g_tap
            assign nxt_o[i] = cur_i[i+1] ^ fb;
        end else begin : g_plain
            assign nxt_o[i] = cur_i[i+1];
        end
    end
endmodule

// File: rtl/lfsr_seed_guard.sv
// Module: lfsr_seed_guard
// Turns an all-zero seed into 1 so that a load can never park the
// register in its zero fixed point.
// Assumes: nothing beyond WIDTH >= 1.
module lfsr_seed_guard #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] safe_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Swap zero for the value 1; pass any other seed through
    always_comb begin
        safe_o = (seed_i == '0) ? ONE : seed_i;
    end
endmodule

// File: rtl/lfsr_state_reg.sv
// Module: lfsr_state_reg
// Holds the register. Reset wins over load, and load wins over stepping.
// Assumes: the synchronous active-low reset is held for at least one edge.
module lfsr_state_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_safe_i,
    input  logic [WIDTH-1:0] step_i,
    output logic [WIDTH-1:0] state_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Register update: reset, then load, then a normal step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ONE;
        end else if (load_i) begin
            state_q <= seed_safe_i;
        end else begin
            state_q <= step_i;
        end
    end

    // R1 R9
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ONE));

    // R7
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/galois_lfsr.sv
// Module: galois_lfsr (top)
// N-bit Galois shift register. The polynomial is fixed by TAP_MASK. The
// seed can be loaded, with zero replaced by 1. The serial bit is bit 0.
// Assumes: TAP_MASK describes a primitive polynomial for full period.
module galois_lfsr #(
    parameter int               WIDTH    = 4,
    parameter logic [WIDTH-1:0] TAP_MASK = galois_lfsr_pkg::DEFAULT_MASK4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic             serial_o,
    output logic [WIDTH-1:0] state_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] seed_safe;

    lfsr_step #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_step (
        .cur_i (cur),
        .nxt_o (nxt)
    );

    lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
        .seed_i (seed_i),
        .safe_o (seed_safe)
    );

    lfsr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .seed_safe_i (seed_safe),
        .step_i      (nxt),
        .state_q     (cur)
    );

    // Outputs: the whole state and the bit that will leave next
    assign state_o  = cur;
    assign serial_o = cur[0];

    // R2: with a zero feedback bit the step is a plain right shift
    // R2
    plain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !state_o[0]) |=> (state_o == ($past(state_o) >> 1)));

    // R3
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (state_o == $past(seed_i)));

    // R4
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (state_o == ONE));
endmodule

// File: tb/galois_lfsr_test.sv
module galois_lfsr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [3:0] seed4 = '0;
    logic [7:0] seed8 = '0;
    logic       ser4, ser8;
    logic [3:0] st4;
    logic [7:0] st8;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [3:0] exp4;
    logic [7:0] exp8;

    always #10 clk = ~clk;   // 50 MHz

    galois_lfsr uut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed4),
        .serial_o(ser4), .state_o(st4)
    );

    galois_lfsr #(.WIDTH(8), .TAP_MASK(8'hB8)) uut8 (
        .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed8),
        .serial_o(ser8), .state_o(st8)
    );

    function automatic logic [3:0] model4(input logic [3:0] s);
        return (s >> 1) ^ (s[0] ? 4'hC : 4'h0);
    endfunction

    function automatic logic [7:0] model8(input logic [7:0] s);
        return (s >> 1) ^ (s[0] ? 8'hB8 : 8'h00);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Compare both instances with the model (called mid-cycle)
    task automatic compare_all(input string tag);
        check(tag, {28'd0, st4}, {28'd0, exp4});
        check(tag, {24'd0, st8}, {24'd0, exp8});
        check("R8 serial4", {31'd0, ser4}, {31'd0, st4[0]});
        check("R8 serial8", {31'd0, ser8}, {31'd0, st8[0]});
        if (rst_n) begin
            check("R7 nonzero4", {31'd0, (st4 == 4'd0)}, 32'd0);
            check("R7 nonzero8", {31'd0, (st8 == 8'd0)}, 32'd0);
        end
    endtask

    // Apply inputs at a falling edge, update the model, check at the next falling edge
    task automatic step(input logic r, input logic l, input logic [3:0] s4,
                        input logic [7:0] s8, input string tag);
        rst_n = r; load = l; seed4 = s4; seed8 = s8;
        if (!r) begin
            exp4 = 4'd1; exp8 = 8'd1;
        end else if (l) begin
            exp4 = (s4 == 0) ? 4'd1 : s4;
            exp8 = (s8 == 0) ? 8'd1 : s8;
        end else begin
            exp4 = model4(exp4); exp8 = model8(exp8);
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit seen4 [16];
        bit seen8 [256];
        void'($urandom(32'd4242));
        exp4 = 4'd1; exp8 = 8'd1;
        @(negedge clk);
        // R9: reset with load high and a seed present
        step(1'b0, 1'b1, 4'h9, 8'h5A, "R9 reset over load");
        step(1'b0, 1'b0, 4'h0, 8'h00, "R1 reset value");

        // R2: free running from 1
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 4'h0, 8'h00, "R2 step");

        // R3 directed load, R4 zero seed
        step(1'b1, 1'b1, 4'hF, 8'hFF, "R3 load all ones");
        step(1'b1, 1'b1, 4'h0, 8'h00, "R4 zero seed");
        step(1'b1, 1'b0, 4'h0, 8'h00, "R2 after load");

        // R5: period of 15 from seed 1
        step(1'b1, 1'b1, 4'h1, 8'h01, "R3 load one");
        foreach (seen4[k]) seen4[k] = 1'b0;
        seen4[st4] = 1'b1;
        for (int i = 1; i <= 15; i++) begin
            step(1'b1, 1'b0, 4'h0, 8'h00, "R2 period run");
            if (i < 15) begin
                check("R5 no early repeat", {31'd0, seen4[st4]}, 32'd0);
                seen4[st4] = 1'b1;
            end else begin
                check("R5 return after 15", {28'd0, st4}, 32'd1);
            end
        end

        // R6: period of 255 for the 8-bit build from seed 0x3C
        step(1'b1, 1'b1, 4'h7, 8'h3C, "R3 load 8-bit start");
        foreach (seen8[k]) seen8[k] = 1'b0;
        seen8[st8] = 1'b1;
        for (int i = 1; i <= 255; i++) begin
            step(1'b1, 1'b0, 4'h0, 8'h00, "R2 period run 8");
            if (i < 255) begin
                if (seen8[st8]) check("R6 no early repeat", {24'd0, st8}, 32'd0);
                seen8[st8] = 1'b1;
            end else begin
                check("R6 return after 255", {24'd0, st8}, 32'h3C);
            end
        end

        // Random mix: loads against steps, zero seeds, occasional reset under load
        for (int i = 0; i < 400; i++) begin
            logic l, r;
            logic [3:0] s4;
            logic [7:0] s8;
            l  = ($urandom % 8) == 0;
            r  = ($urandom % 64) != 0;
            s4 = (($urandom % 4) == 0) ? 4'h0 : 4'($urandom);
            s8 = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
            if (!r) l = 1'b1;
            step(r, l, s4, s8, !r ? "R9 random reset" : (l ? "R3 R4 random load" : "R2 random step"));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule